// File: doc/BRIEF.md
# Single-Wire Bus Device ROM Command Handler

This block is the device-side front end of a single-wire open-drain bus. It watches a sampled copy of the bus line and tracks how long the line stays low. A long low period is a bus reset. The block answers each reset with a presence pulse and then receives an 8-bit ROM command in the bit slots the master starts. It then runs one of four identity functions against a 64-bit identity word supplied on a port:

- **Read:** shift the identity out.
- **Match:** compare the identity with bits from the master.
- **Skip:** select at once.
- **Search:** take part in bit-wise elimination with the other devices on the bus.

The block never drives the line high. Its only drive output is a pull-low enable, so several devices can share the wire as a wired AND. A `selected` flag tells the downstream memory-function logic that this device has been addressed. On a failed match, a lost search or an unknown opcode, the block stays silent until the next bus reset.

All timing is counted in ticks of a one-microsecond strobe input. This allows the block to run from any system clock that is fast enough to see each tick.

Top module: `owire_rom_slave`

## Requirements
- R1: A bus low time of at least RESET_US ticks aborts any state. It clears `selected` by the next cycle and releases the line. After the line goes high again, the block starts a new transaction. Out of system reset, the block ignores all bit slots until it has seen such a bus reset.
- R2: After the reset low period ends, the block waits about PRES_WAIT_US ticks. It then pulls low for exactly PRES_LEN_US ticks. No bit-slot drive overlaps the presence pulse.
- R3: Each bit slot starts on a falling edge of the line. The block samples the slot SAMPLE_US ticks after that edge. Command bits arrive least significant bit first, eight per command.
- R4: Opcode 0x33 sends ID_BITS identity bits, bit 0 first, one per slot the master starts. After the last bit, `selected` is raised.
- R5: Opcode 0x55 reads ID_BITS bits from the master. If every bit equals the identity bit at the same position, `selected` rises after the last bit and stays high until the next bus reset.
- R6: After any mismatching bit under 0x55, the block pulls nothing and keeps `selected` low until the next bus reset.
- R7: Opcode 0xCC raises `selected` at the end of the command byte.
- R8: Opcode 0xF0 uses three slots per identity position: the block sends the bit, sends its complement, then reads the master's choice. When every choice agrees with the identity, `selected` rises after the last position. Another device pulling low in a send slot does not disturb the block.
- R9: Under 0xF0, a chosen bit that differs from the identity bit makes the block withdraw. It drives no further slots and never raises `selected` before the next bus reset.
- R10: Any other opcode leaves the block silent until the next bus reset.
- R11: The line may stay idle high between slots for any length of time without losing progress.
- R12: To send a 0, the block pulls low from the slot's falling edge until TX_HOLD_US ticks later. To send a 1, it leaves the line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe once per microsecond |
| bus_in | input | 1 | Synchronised level of the bus line (1 = released) |
| id_code | input | ID_BITS | Device identity, bit 0 sent first |
| bus_pull | output | 1 | 1 = pull the bus line low |
| selected | output | 1 | Device addressed; memory functions may proceed |

## Verification
The match function is swept with the exact identity and with a single flipped bit at every position. This separates a correct compare-and-withdraw from one that checks only some positions or that reports too early. The search function is run to completion, and also with a wrong choice at the first, a middle and the last position. Each send slot is read back to confirm the true and complement pair and the silence after withdrawal. One send slot is overdriven by a simulated second device to show the wired-AND outcome. Read, skip, unknown opcodes, a long idle gap, and a reset in the middle of a read complete the patterns. Each pattern checks presence timing and the pull duration of every slot.

// File: rtl/owire_pkg.sv
// Shared types and constants for the single-wire ROM command handler.
// Assumes commands are always eight bits, sent least significant bit first.
package owire_pkg;

    localparam int CMD_BITS = 8;

    localparam logic [7:0] OP_READ   = 8'h33;
    localparam logic [7:0] OP_MATCH  = 8'h55;
    localparam logic [7:0] OP_SKIP   = 8'hCC;
    localparam logic [7:0] OP_SEARCH = 8'hF0;

    typedef enum logic [3:0] {
        ST_DEAD,      // waiting for a bus reset, line untouched
        ST_RST,       // reset low period seen, waiting for release
        ST_PRES,      // presence pulse in progress
        ST_CMD,       // collecting the command byte
        ST_READ,      // sending identity bits
        ST_MATCH,     // comparing master bits with identity
        ST_SRCH_TX,   // search: sending the true bit
        ST_SRCH_CMP,  // search: sending the complement
        ST_SRCH_RX,   // search: reading the master's choice
        ST_SEL        // addressed, hand-over to memory functions
    } rom_state_e;

endpackage

// File: rtl/owire_line_watch.sv
// Line observer: finds falling edges, measures low time for reset detection,
// times each bit slot from its falling edge and emits one sample strobe.
// Assumes bus_in is already synchronised to clk and tick_us is one cycle wide.
module owire_line_watch #(
    parameter int RESET_US  = 480,
    parameter int SAMPLE_US = 30,
    parameter int SF_W      = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_us,
    input  logic            bus_in,
    output logic            fall,
    output logic            reset_hit,
    output logic            strobe,
    output logic [SF_W-1:0] since_fall
);
    localparam int LC_W = $clog2(RESET_US + 1);
    localparam logic [SF_W-1:0] SF_SAT = {SF_W{1'b1}};

    logic            prev_q;
    logic [LC_W-1:0] low_cnt;
    logic            slot_live;

    assign fall      = prev_q & ~bus_in;
    assign reset_hit = (low_cnt >= LC_W'(RESET_US));
    assign strobe    = slot_live & ~fall & (since_fall >= SF_W'(SAMPLE_US));

    // remember last line level for edge finding
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= bus_in;
    end

    // count ticks of continuous low level, saturating at the reset limit
    always_ff @(posedge clk) begin
        if (!rst_n || bus_in)                          low_cnt <= '0;
        else if (tick_us && low_cnt != LC_W'(RESET_US)) low_cnt <= low_cnt + 1'b1;
    end

    // ticks since the most recent falling edge, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                             since_fall <= SF_SAT;
        else if (fall)                          since_fall <= '0;
        else if (tick_us && since_fall != SF_SAT) since_fall <= since_fall + 1'b1;
    end

    // a slot is live from its edge until its single sample strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      slot_live <= 1'b0;
        else if (fall)   slot_live <= 1'b1;
        else if (strobe) slot_live <= 1'b0;
    end

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

endmodule

// File: rtl/owire_presence.sv
// Presence pulse generator: after a start request waits WAIT_US ticks, then
// requests a low drive for LEN_US ticks and signals completion.
// Assumes start arrives only while idle; abort cancels at once.
module owire_presence #(
    parameter int WAIT_US = 20,
    parameter int LEN_US  = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic start,
    input  logic abort,
    output logic pull,
    output logic done
);
    localparam int END_US = WAIT_US + LEN_US;
    localparam int PC_W   = $clog2(END_US + 1);

    logic            busy;
    logic [PC_W-1:0] cnt;
    logic            pull_q;

    assign done = busy & (cnt >= PC_W'(END_US));
    assign pull = pull_q;

    // run the wait-then-drive timer
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy && tick_us) begin
            cnt <= cnt + 1'b1;
        end
    end

    // drive low inside the presence window
    always_ff @(posedge clk) begin
        if (!rst_n || abort) pull_q <= 1'b0;
        else pull_q <= busy && (cnt >= PC_W'(WAIT_US)) && (cnt < PC_W'(END_US));
    end

    assert_pres_abort_R1: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !pull);

endmodule

// File: rtl/owire_tx_slot.sv
// Bit-slot transmitter: when armed with a 0 at a slot's falling edge, holds
// the line low until HOLD_US ticks after that edge; a 1 leaves it released.
// Assumes since_fall restarts at zero on the same edge that raises fall.
module owire_tx_slot #(
    parameter int HOLD_US = 45,
    parameter int SF_W    = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fall,
    input  logic            arm,
    input  logic            tx_bit,
    input  logic [SF_W-1:0] since_fall,
    input  logic            abort,
    output logic            pull
);
    logic pull_q;
    assign pull = pull_q;

    // start the low drive on an armed 0 slot, end it at the hold limit
    always_ff @(posedge clk) begin
        if (!rst_n || abort)                 pull_q <= 1'b0;
        else if (fall && arm && !tx_bit)     pull_q <= 1'b1;
        else if (since_fall >= SF_W'(HOLD_US)) pull_q <= 1'b0;
    end

    assert_tx_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pull && !fall && since_fall >= SF_W'(HOLD_US)) |=> !pull);

endmodule

// File: rtl/owire_rom_slave.sv
// Single-wire bus device ROM command handler (top). Detects bus resets,
// answers with presence, decodes the ROM command and runs read, match, skip
// or search against id_code; raises selected when addressed.
// Assumes ID_BITS >= 8, bus_in synchronised, tick_us one cycle per microsecond.
module owire_rom_slave
    import owire_pkg::*;
#(
    parameter int ID_BITS      = 64,
    parameter int RESET_US     = 480,
    parameter int PRES_WAIT_US = 20,
    parameter int PRES_LEN_US  = 120,
    parameter int SAMPLE_US    = 30,
    parameter int TX_HOLD_US   = 45
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_us,
    input  logic               bus_in,
    input  logic [ID_BITS-1:0] id_code,
    output logic               bus_pull,
    output logic               selected
);
    localparam int IDX_W    = $clog2(ID_BITS);
    localparam int SPAN_US  = (TX_HOLD_US > SAMPLE_US) ? TX_HOLD_US : SAMPLE_US;
    localparam int SF_W     = $clog2(SPAN_US + 2) + 1;
    localparam logic [IDX_W-1:0] ID_LAST  = IDX_W'(ID_BITS - 1);
    localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_BITS - 1);

    rom_state_e           state;
    logic [IDX_W-1:0]     idx;
    logic [CMD_BITS-1:0]  cmd_q;
    logic [CMD_BITS-1:0]  cmd_next;
    logic                 fall, reset_hit, strobe;
    logic [SF_W-1:0]      since_fall;
    logic                 pres_start, pres_pull, pres_done;
    logic                 tx_arm, tx_bit, tx_pull;
    logic                 id_bit;

    owire_line_watch #(
        .RESET_US (RESET_US),
        .SAMPLE_US(SAMPLE_US),
        .SF_W     (SF_W)
    ) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_us   (tick_us),
        .bus_in    (bus_in),
        .fall      (fall),
        .reset_hit (reset_hit),
        .strobe    (strobe),
        .since_fall(since_fall)
    );

    owire_presence #(
        .WAIT_US(PRES_WAIT_US),
        .LEN_US (PRES_LEN_US)
    ) u_pres (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_us(tick_us),
        .start  (pres_start),
        .abort  (reset_hit),
        .pull   (pres_pull),
        .done   (pres_done)
    );

    owire_tx_slot #(
        .HOLD_US(TX_HOLD_US),
        .SF_W   (SF_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall      (fall),
        .arm       (tx_arm),
        .tx_bit    (tx_bit),
        .since_fall(since_fall),
        .abort     (reset_hit),
        .pull      (tx_pull)
    );

    // identity bit at the current position and the slot drive request
    always_comb begin
        id_bit   = id_code[idx];
        cmd_next = {bus_in, cmd_q[CMD_BITS-1:1]};
        tx_arm   = (state == ST_READ) || (state == ST_SRCH_TX) || (state == ST_SRCH_CMP);
        tx_bit   = (state == ST_SRCH_CMP) ? ~id_bit : id_bit;
        pres_start = (state == ST_RST) && !reset_hit && bus_in;
    end

    assign bus_pull = pres_pull | tx_pull;
    assign selected = (state == ST_SEL);

    // advance the ROM command state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_DEAD;
            idx   <= '0;
            cmd_q <= '0;
        end else if (reset_hit) begin
            state <= ST_RST;
            idx   <= '0;
        end else begin
            case (state)
                ST_RST: if (pres_start) state <= ST_PRES;
                ST_PRES: if (pres_done) begin
                    state <= ST_CMD;
                    idx   <= '0;
                end
                ST_CMD: if (strobe) begin
                    cmd_q <= cmd_next;
                    if (idx == CMD_LAST) begin
                        idx <= '0;
                        case (cmd_next)
                            OP_READ:   state <= ST_READ;
                            OP_MATCH:  state <= ST_MATCH;
                            OP_SKIP:   state <= ST_SEL;
                            OP_SEARCH: state <= ST_SRCH_TX;
                            default:   state <= ST_DEAD;
                        endcase
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_READ: if (strobe) begin
                    if (idx == ID_LAST) state <= ST_SEL;
                    else                idx   <= idx + 1'b1;
                end
                ST_MATCH: if (strobe) begin
                    if (bus_in != id_bit)    state <= ST_DEAD;
                    else if (idx == ID_LAST) state <= ST_SEL;
                    else                     idx   <= idx + 1'b1;
                end
                ST_SRCH_TX:  if (strobe) state <= ST_SRCH_CMP;
                ST_SRCH_CMP: if (strobe) state <= ST_SRCH_RX;
                ST_SRCH_RX: if (strobe) begin
                    if (bus_in != id_bit)    state <= ST_DEAD;
                    else if (idx == ID_LAST) state <= ST_SEL;
                    else begin
                        idx   <= idx + 1'b1;
                        state <= ST_SRCH_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_reset_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reset_hit |=> !selected);

    assert_single_driver_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pres_pull && tx_pull));

    assert_select_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !reset_hit) |=> selected);

    assert_dead_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEAD) |-> !tx_pull);

endmodule

// File: tb/sim_owire_rom_slave.sv
// Bench: a bus master model drives resets and bit slots through a wired-AND
// line; expected bits come from the identity constant and the opcode rules.
module sim_owire_rom_slave;
    localparam int ID_BITS   = 16;
    localparam int RESET_US  = 480;
    localparam int PWAIT     = 20;
    localparam int PLEN      = 120;
    localparam int SAMPLE_US = 30;
    localparam int HOLD_US   = 45;
    localparam int SLOT      = 70;
    localparam logic [ID_BITS-1:0] ID_VAL = 16'hB38D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b1;
    logic master_low = 1'b0;
    logic other_low = 1'b0;
    logic bus_line;
    logic bus_pull, selected;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;
    assign bus_line = ~(master_low | bus_pull | other_low);

    owire_rom_slave #(
        .ID_BITS(ID_BITS), .RESET_US(RESET_US), .PRES_WAIT_US(PWAIT),
        .PRES_LEN_US(PLEN), .SAMPLE_US(SAMPLE_US), .TX_HOLD_US(HOLD_US)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bus_in(bus_line),
        .id_code(ID_VAL), .bus_pull(bus_pull), .selected(selected)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bus reset followed by presence measurement (R1, R2)
    task automatic bus_reset();
        int first = -1;
        int len = 0;
        @(negedge clk) master_low = 1'b1;
        idle(RESET_US + 20);
        chk(selected == 1'b0, "R1 deselect on reset", int'(selected), 0);
        master_low = 1'b0;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            if (bus_pull) begin
                if (first < 0) first = t;
                len++;
            end
        end
        chk(len == PLEN, "R2 presence length", len, PLEN);
        chk(first >= PWAIT && first <= PWAIT + 5, "R2 presence delay", first, PWAIT);
    endtask

    task automatic write_bit(input logic b);
        @(negedge clk) master_low = 1'b1;
        idle(b ? 3 : 60);
        master_low = 1'b0;
        idle(b ? SLOT - 3 : SLOT - 60);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) write_bit(v[i]);
    endtask

    // master read slot: returns the sampled level and the device pull time
    task automatic read_bit(output logic v, output int plen, input bit extra);
        plen = 0;
        v = 1'b1;
        @(negedge clk) begin master_low = 1'b1; other_low = extra; end
        for (int t = 1; t < SLOT; t++) begin
            @(negedge clk);
            if (t == 2) master_low = 1'b0;
            if (t == 40) other_low = 1'b0;
            if (t == 12) v = bus_line;
            if (bus_pull) plen++;
        end
    endtask

    task automatic expect_read(input logic exp, input bit extra, input string req);
        logic v;
        int pl;
        read_bit(v, pl, extra);
        chk(v == (exp & ~extra), req, int'(v), int'(exp & ~extra));
        if (exp) chk(pl == 0, "R12 released for 1", pl, 0);
        else     chk(pl >= HOLD_US - 2 && pl <= HOLD_US + 2, "R12 hold for 0", pl, HOLD_US);
    endtask

    task automatic expect_silent(input string req);
        logic v;
        int pl;
        read_bit(v, pl, 1'b0);
        chk(pl == 0 && v == 1'b1, req, pl, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        idle(5);
        rst_n = 1'b1;
        idle(3);
        chk(bus_pull == 1'b0, "R1 reset state pull", int'(bus_pull), 0);
        chk(selected == 1'b0, "R1 reset state selected", int'(selected), 0);
        // no bus reset yet: a skip command must be ignored (R1)
        send_byte(8'hCC);
        chk(selected == 1'b0, "R1 slots ignored before bus reset", int'(selected), 0);

        // R4 read identity, bit 0 first
        bus_reset();
        send_byte(8'h33);
        for (int i = 0; i < ID_BITS; i++) expect_read(ID_VAL[i], 1'b0, "R4 read bit");
        chk(selected == 1'b1, "R4 selected after read", int'(selected), 1);

        // R7 skip
        bus_reset();
        send_byte(8'hCC);
        chk(selected == 1'b1, "R7 skip selects", int'(selected), 1);

        // R5/R6 match sweep: exact and one flipped bit at every position, R11 gap
        for (int pos = -1; pos < ID_BITS; pos++) begin
            bus_reset();
            send_byte(8'h55);
            for (int i = 0; i < ID_BITS; i++) begin
                if (pos < 0 && i == 5) idle(3000);
                write_bit(ID_VAL[i] ^ (i == pos));
            end
            if (pos < 0) begin
                chk(selected == 1'b1, "R5 R11 exact match selects", int'(selected), 1);
            end else begin
                chk(selected == 1'b0, "R6 mismatch not selected", int'(selected), 0);
                expect_silent("R6 silent after mismatch");
            end
        end

        // R8/R9 search: full run with a wired-AND overdrive, then withdrawals
        for (int k = 0; k < 4; k++) begin
            int pos;
            bit gone;
            pos = (k == 0) ? -1 : (k == 1) ? 0 : (k == 2) ? 7 : ID_BITS - 1;
            gone = 1'b0;
            bus_reset();
            send_byte(8'hF0);
            for (int i = 0; i < ID_BITS; i++) begin
                if (gone) begin
                    expect_silent("R9 withdrawn true slot");
                    expect_silent("R9 withdrawn complement slot");
                end else begin
                    expect_read(ID_VAL[i], (pos < 0 && i == 3), "R8 search true bit");
                    expect_read(~ID_VAL[i], 1'b0, "R8 search complement bit");
                end
                write_bit(ID_VAL[i] ^ (i == pos));
                if (i == pos) gone = 1'b1;
            end
            if (pos < 0) chk(selected == 1'b1, "R8 search completes", int'(selected), 1);
            else         chk(selected == 1'b0, "R9 withdraw not selected", int'(selected), 0);
        end

        // R10 unknown opcodes, including near neighbours of valid ones
        for (int k = 0; k < 4; k++) begin
            logic [7:0] op;
            op = (k == 0) ? 8'h00 : (k == 1) ? 8'h5A : (k == 2) ? 8'hFF : 8'h34;
            bus_reset();
            send_byte(op);
            chk(selected == 1'b0, "R10 unknown not selected", int'(selected), 0);
            expect_silent("R10 unknown silent");
            expect_silent("R10 unknown silent");
        end

        // R1 reset in the middle of a read, then a fresh transaction (R3)
        bus_reset();
        send_byte(8'h33);
        for (int i = 0; i < 3; i++) expect_read(ID_VAL[i], 1'b0, "R3 partial read");
        bus_reset();
        send_byte(8'hCC);
        chk(selected == 1'b1, "R1 restart after mid-read reset", int'(selected), 1);
        bus_reset();
        chk(selected == 1'b0, "R1 reset clears selection", int'(selected), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule